// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block chooses which pending DRAM request goes next. Each cycle it registers a snapshot of a small request queue (valid bit, flat bank id, row, and a write flag per slot), the availability time of every bank, and a direction select. From that snapshot and its own open-row table it decides combinationally which slot to grant. Requests that land on a bank's currently open row always go first. When none do, the request whose bank becomes free soonest goes instead. Alongside the grant it says whether the row should be closed by an auto-precharge once the access is done, based on the other requests still waiting.

The open-row table is kept inside the block. It is driven by activate and precharge notifications from the command stage. It is also driven by the issue strobe: a granted access that carries the auto-precharge flag closes its bank's row. Reads and writes are picked by two instances of one selector, and the direction select chooses which result is used. Address decoding and command timing belong to neighbouring blocks.

Top module: `rowhit_sched`

## Requirements
- R1: After synchronous reset every bank row is closed and grant_valid_o is 0 until a valid eligible slot is sampled.
- R2: A slot is eligible when its valid bit is 1 and its write flag equals drain_writes_i (1 selects writes, 0 reads); grant_valid_o is 1 exactly when at least one slot is eligible, and grant_idx_o always names an eligible slot.
- R3: A slot hits when its bank has an open row equal to its row; if any eligible slot hits, the grant goes to a hit and grant_hit_o is 1.
- R4: Among several eligible hits the lowest slot index wins.
- R5: With no eligible hit, the grant goes to the eligible slot whose bank has the smallest unsigned availability value, ties going to the lowest slot index, and grant_hit_o is 0.
- R6: Read and write selections obey identical rules; only drain_writes_i decides which class competes.
- R7: grant_autopre_o is 1 when no other valid slot (either direction) holds the granted bank and row, and at least one other valid slot holds the granted bank with a different row.
- R8: If another valid slot holds the granted bank and row, grant_autopre_o is 0.
- R9: act_valid_i opens row act_row_i in bank act_bank_i from the next cycle on; a same-cycle close of that bank loses to the activate.
- R10: pre_valid_i closes bank pre_bank_i from the next cycle on.
- R11: issue_i while grant_valid_o and grant_autopre_o are 1 closes the granted slot's bank from the next cycle on.
- R12: The grant reflects queue, availability and direction inputs sampled at the previous rising edge; input changes between edges leave the outputs unchanged.

Field positions: slot i uses q_bank_i[i*BW +: BW] and q_row_i[i*RW +: RW]; bank b uses bank_ready_i[b*TW +: TW]. Here BW is log2(NBANK), RW is ROW_W and TW is TIME_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid_i | input | QDEPTH | Slot valid bits |
| q_write_i | input | QDEPTH | Slot write flags (1 = write) |
| q_bank_i | input | QDEPTH*log2(NBANK) | Flat bank id per slot |
| q_row_i | input | QDEPTH*ROW_W | Row per slot |
| bank_ready_i | input | NBANK*TIME_W | Availability time per bank |
| drain_writes_i | input | 1 | 1 = select among writes, 0 = reads |
| act_valid_i | input | 1 | Activate notification |
| act_bank_i | input | log2(NBANK) | Activated bank |
| act_row_i | input | ROW_W | Activated row |
| pre_valid_i | input | 1 | Precharge notification |
| pre_bank_i | input | log2(NBANK) | Precharged bank |
| issue_i | input | 1 | Current grant accepted |
| grant_valid_o | output | 1 | A slot is granted |
| grant_idx_o | output | log2(QDEPTH) | Granted slot index |
| grant_hit_o | output | 1 | Granted slot hits its open row |
| grant_autopre_o | output | 1 | Close the row after this access |

## Verification
The bench builds the block with its defaults: eight slots, eight flat banks, 8-bit rows and 8-bit availability times. Random rows are drawn from only four values and banks are drawn mostly from four of the eight. This makes row hits, same-bank conflicts and multiple hits common enough to exercise the lowest-index rule and both outcomes of the close decision. Availability values are kept to a narrow range so that equal times occur often and the tie rule is tested. With eight slots, the close check also sees cases where several competing slots share the granted bank.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

    localparam int DEF_QDEPTH = 8;
    localparam int DEF_NBANK  = 8;
    localparam int DEF_ROW_W  = 8;
    localparam int DEF_TIME_W = 8;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_HIT  = 2'd1,
        PICK_MISS = 2'd2
    } pick_kind_e;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rhs_bank_table.sv
module rhs_bank_table #(
    parameter int NBANK  = rhs_pkg::DEF_NBANK,
    parameter int ROW_W  = rhs_pkg::DEF_ROW_W,
    parameter int BANK_W = rhs_pkg::idx_width(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_valid,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              ap_valid,
    input  logic [BANK_W-1:0] ap_bank,
    output logic [NBANK-1:0]  open_vld,
    output logic [ROW_W-1:0]  open_row [NBANK]
);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic do_act;
            logic do_close;
            assign do_act   = act_valid && (act_bank == BANK_W'(b));
            assign do_close = (pre_valid && (pre_bank == BANK_W'(b))) ||
                              (ap_valid  && (ap_bank  == BANK_W'(b)));

            always_ff @(posedge clk) begin
                if (rst) begin
                    open_vld[b] <= 1'b0;
                    open_row[b] <= '0;
                end else if (do_act) begin
                    open_vld[b] <= 1'b1;
                    open_row[b] <= act_row;
                end else if (do_close) begin
                    open_vld[b] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rhs_pick.sv
module rhs_pick #(
    parameter int QDEPTH = rhs_pkg::DEF_QDEPTH,
    parameter int NBANK  = rhs_pkg::DEF_NBANK,
    parameter int ROW_W  = rhs_pkg::DEF_ROW_W,
    parameter int TIME_W = rhs_pkg::DEF_TIME_W,
    parameter int BANK_W = rhs_pkg::idx_width(NBANK),
    parameter int IDX_W  = rhs_pkg::idx_width(QDEPTH),
    parameter bit DIR    = 1'b0
) (
    input  logic [QDEPTH-1:0]  valid,
    input  logic [QDEPTH-1:0]  write,
    input  logic [BANK_W-1:0]  bank [QDEPTH],
    input  logic [ROW_W-1:0]   row  [QDEPTH],
    input  logic [NBANK-1:0]   open_vld,
    input  logic [ROW_W-1:0]   open_row [NBANK],
    input  logic [TIME_W-1:0]  ready [NBANK],
    output rhs_pkg::pick_kind_e kind,
    output logic [IDX_W-1:0]   idx
);
    import rhs_pkg::*;

    logic [QDEPTH-1:0] elig;
    logic [QDEPTH-1:0] hit;
    logic [TIME_W-1:0] ent_t [QDEPTH];

    generate
        for (genvar i = 0; i < QDEPTH; i++) begin : g_ent
            assign elig[i]  = valid[i] && (write[i] == DIR);
            assign hit[i]   = elig[i] && open_vld[bank[i]] &&
                              (open_row[bank[i]] == row[i]);
            assign ent_t[i] = ready[bank[i]];
        end
    endgenerate

    logic [TIME_W-1:0] best_t;
    logic              found;

    always_comb begin
        kind   = PICK_NONE;
        idx    = '0;
        best_t = '0;
        found  = 1'b0;
        // highest index first so the lowest hit overwrites last
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                kind = PICK_HIT;
                idx  = IDX_W'(i);
            end
        end
        if (kind == PICK_NONE) begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (elig[i] && (!found || (ent_t[i] < best_t))) begin
                    found  = 1'b1;
                    best_t = ent_t[i];
                    idx    = IDX_W'(i);
                end
            end
            if (found) kind = PICK_MISS;
        end
    end

endmodule

// File: rtl/rhs_close_policy.sv
module rhs_close_policy #(
    parameter int QDEPTH = rhs_pkg::DEF_QDEPTH,
    parameter int ROW_W  = rhs_pkg::DEF_ROW_W,
    parameter int BANK_W = 3,
    parameter int IDX_W  = rhs_pkg::idx_width(QDEPTH)
) (
    input  logic [QDEPTH-1:0] valid,
    input  logic [BANK_W-1:0] bank [QDEPTH],
    input  logic [ROW_W-1:0]  row  [QDEPTH],
    input  logic              sel_valid,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic              autopre
);

    logic [BANK_W-1:0] sel_bank;
    logic [ROW_W-1:0]  sel_row;
    logic              keep;
    logic              conflict;

    assign sel_bank = bank[sel_idx];
    assign sel_row  = row[sel_idx];

    always_comb begin
        keep     = 1'b0;
        conflict = 1'b0;
        for (int j = 0; j < QDEPTH; j++) begin
            if (valid[j] && (IDX_W'(j) != sel_idx) && (bank[j] == sel_bank)) begin
                if (row[j] == sel_row) keep     = 1'b1;
                else                   conflict = 1'b1;
            end
        end
    end

    assign autopre = sel_valid && conflict && !keep;

endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
    parameter int QDEPTH = rhs_pkg::DEF_QDEPTH,
    parameter int NBANK  = rhs_pkg::DEF_NBANK,
    parameter int ROW_W  = rhs_pkg::DEF_ROW_W,
    parameter int TIME_W = rhs_pkg::DEF_TIME_W,
    localparam int BANK_W = rhs_pkg::idx_width(NBANK),
    localparam int IDX_W  = rhs_pkg::idx_width(QDEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [QDEPTH-1:0]          q_valid_i,
    input  logic [QDEPTH-1:0]          q_write_i,
    input  logic [QDEPTH*BANK_W-1:0]   q_bank_i,
    input  logic [QDEPTH*ROW_W-1:0]    q_row_i,
    input  logic [NBANK*TIME_W-1:0]    bank_ready_i,
    input  logic                       drain_writes_i,
    input  logic                       act_valid_i,
    input  logic [BANK_W-1:0]          act_bank_i,
    input  logic [ROW_W-1:0]           act_row_i,
    input  logic                       pre_valid_i,
    input  logic [BANK_W-1:0]          pre_bank_i,
    input  logic                       issue_i,
    output logic                       grant_valid_o,
    output logic [IDX_W-1:0]           grant_idx_o,
    output logic                       grant_hit_o,
    output logic                       grant_autopre_o
);
    import rhs_pkg::*;

    // registered snapshot of the queue and bank availability
    logic [QDEPTH-1:0] snap_valid;
    logic [QDEPTH-1:0] snap_write;
    logic [BANK_W-1:0] snap_bank  [QDEPTH];
    logic [ROW_W-1:0]  snap_row   [QDEPTH];
    logic [TIME_W-1:0] snap_ready [NBANK];
    logic              snap_dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_valid <= '0;
            snap_write <= '0;
            snap_dir   <= DIR_READ;
            for (int i = 0; i < QDEPTH; i++) begin
                snap_bank[i] <= '0;
                snap_row[i]  <= '0;
            end
            for (int b = 0; b < NBANK; b++) snap_ready[b] <= '0;
        end else begin
            snap_valid <= q_valid_i;
            snap_write <= q_write_i;
            snap_dir   <= drain_writes_i;
            for (int i = 0; i < QDEPTH; i++) begin
                snap_bank[i] <= q_bank_i[i*BANK_W +: BANK_W];
                snap_row[i]  <= q_row_i[i*ROW_W +: ROW_W];
            end
            for (int b = 0; b < NBANK; b++)
                snap_ready[b] <= bank_ready_i[b*TIME_W +: TIME_W];
        end
    end

    // open-row table
    logic [NBANK-1:0]  open_vld;
    logic [ROW_W-1:0]  open_row [NBANK];
    logic              ap_valid;
    logic [BANK_W-1:0] grant_bank;
    logic [ROW_W-1:0]  grant_row;

    assign grant_bank = snap_bank[grant_idx_o];
    assign grant_row  = snap_row[grant_idx_o];
    assign ap_valid   = issue_i && grant_valid_o && grant_autopre_o;

    rhs_bank_table #(
        .NBANK (NBANK),
        .ROW_W (ROW_W),
        .BANK_W(BANK_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .act_valid(act_valid_i),
        .act_bank (act_bank_i),
        .act_row  (act_row_i),
        .pre_valid(pre_valid_i),
        .pre_bank (pre_bank_i),
        .ap_valid (ap_valid),
        .ap_bank  (grant_bank),
        .open_vld (open_vld),
        .open_row (open_row)
    );

    // one selector per direction, identical logic
    pick_kind_e       dir_kind [2];
    logic [IDX_W-1:0] dir_idx  [2];

    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            rhs_pick #(
                .QDEPTH(QDEPTH),
                .NBANK (NBANK),
                .ROW_W (ROW_W),
                .TIME_W(TIME_W),
                .BANK_W(BANK_W),
                .IDX_W (IDX_W),
                .DIR   (d[0])
            ) u_pick (
                .valid   (snap_valid),
                .write   (snap_write),
                .bank    (snap_bank),
                .row     (snap_row),
                .open_vld(open_vld),
                .open_row(open_row),
                .ready   (snap_ready),
                .kind    (dir_kind[d]),
                .idx     (dir_idx[d])
            );
        end
    endgenerate

    pick_kind_e sel_kind;
    assign sel_kind      = dir_kind[snap_dir];
    assign grant_idx_o   = dir_idx[snap_dir];
    assign grant_valid_o = (sel_kind != PICK_NONE);
    assign grant_hit_o   = (sel_kind == PICK_HIT);

    rhs_close_policy #(
        .QDEPTH(QDEPTH),
        .ROW_W (ROW_W),
        .BANK_W(BANK_W),
        .IDX_W (IDX_W)
    ) u_close (
        .valid    (snap_valid),
        .bank     (snap_bank),
        .row      (snap_row),
        .sel_valid(grant_valid_o),
        .sel_idx  (grant_idx_o),
        .autopre  (grant_autopre_o)
    );

endmodule

module rowhit_sched_chk #(
    parameter int QDEPTH = 8,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 8,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [QDEPTH-1:0] snap_valid,
    input logic [QDEPTH-1:0] snap_write,
    input logic              snap_dir,
    input logic [NBANK-1:0]  open_vld,
    input logic [ROW_W-1:0]  open_row [NBANK],
    input logic [BANK_W-1:0] grant_bank,
    input logic [ROW_W-1:0]  grant_row,
    input logic              act_valid_i,
    input logic [BANK_W-1:0] act_bank_i,
    input logic [ROW_W-1:0]  act_row_i,
    input logic              pre_valid_i,
    input logic [BANK_W-1:0] pre_bank_i,
    input logic              grant_valid_o,
    input logic [IDX_W-1:0]  grant_idx_o,
    input logic              grant_hit_o,
    input logic              grant_autopre_o
);

    // R2
    grant_elig_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> (snap_valid[grant_idx_o] && (snap_write[grant_idx_o] == snap_dir)));

    // R3
    hit_open_chk: assert property (@(posedge clk) disable iff (rst)
        grant_hit_o |-> (open_vld[grant_bank] && (open_row[grant_bank] == grant_row)));

    // R7
    autopre_grant_chk: assert property (@(posedge clk) disable iff (rst)
        grant_autopre_o |-> grant_valid_o);

    // R9
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act_valid_i |=> (open_vld[$past(act_bank_i)] &&
                         (open_row[$past(act_bank_i)] == $past(act_row_i))));

    // R10
    pre_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_valid_i && !(act_valid_i && (act_bank_i == pre_bank_i)))
            |=> !open_vld[$past(pre_bank_i)]);

endmodule

bind rowhit_sched rowhit_sched_chk #(
    .QDEPTH(QDEPTH),
    .NBANK (NBANK),
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .snap_valid     (snap_valid),
    .snap_write     (snap_write),
    .snap_dir       (snap_dir),
    .open_vld       (open_vld),
    .open_row       (open_row),
    .grant_bank     (grant_bank),
    .grant_row      (grant_row),
    .act_valid_i    (act_valid_i),
    .act_bank_i     (act_bank_i),
    .act_row_i      (act_row_i),
    .pre_valid_i    (pre_valid_i),
    .pre_bank_i     (pre_bank_i),
    .grant_valid_o  (grant_valid_o),
    .grant_idx_o    (grant_idx_o),
    .grant_hit_o    (grant_hit_o),
    .grant_autopre_o(grant_autopre_o)
);

// File: tb/tb_rowhit_sched.sv
module tb_rowhit_sched;

    localparam int QD = 8;
    localparam int NB = 8;
    localparam int RW = 8;
    localparam int TW = 8;
    localparam int BW = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic          tb_valid [QD];
    logic          tb_write [QD];
    logic [BW-1:0] tb_bank  [QD];
    logic [RW-1:0] tb_row   [QD];
    logic [TW-1:0] tb_ready [NB];
    logic          tb_dir, tb_act, tb_pre, tb_issue;
    logic [BW-1:0] tb_act_bank, tb_pre_bank;
    logic [RW-1:0] tb_act_row;

    logic [QD-1:0]    q_valid, q_write;
    logic [QD*BW-1:0] q_bank;
    logic [QD*RW-1:0] q_row;
    logic [NB*TW-1:0] ready;

    always_comb begin
        for (int i = 0; i < QD; i++) begin
            q_valid[i] = tb_valid[i];
            q_write[i] = tb_write[i];
            q_bank[i*BW +: BW] = tb_bank[i];
            q_row[i*RW +: RW]  = tb_row[i];
        end
        for (int b = 0; b < NB; b++) ready[b*TW +: TW] = tb_ready[b];
    end

    logic          g_valid, g_hit, g_ap;
    logic [IW-1:0] g_idx;

    rowhit_sched dut (
        .clk(clk), .rst(rst),
        .q_valid_i(q_valid), .q_write_i(q_write), .q_bank_i(q_bank), .q_row_i(q_row),
        .bank_ready_i(ready), .drain_writes_i(tb_dir),
        .act_valid_i(tb_act), .act_bank_i(tb_act_bank), .act_row_i(tb_act_row),
        .pre_valid_i(tb_pre), .pre_bank_i(tb_pre_bank), .issue_i(tb_issue),
        .grant_valid_o(g_valid), .grant_idx_o(g_idx),
        .grant_hit_o(g_hit), .grant_autopre_o(g_ap)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model of the open-row table
    logic          m_vld [NB];
    logic [RW-1:0] m_row [NB];
    logic          e_valid, e_hit, e_ap;
    logic [IW-1:0] e_idx;
    logic [BW-1:0] e_bank;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < QD; i++) begin
            tb_valid[i] = 0; tb_write[i] = 0; tb_bank[i] = 0; tb_row[i] = 0;
        end
        for (int b = 0; b < NB; b++) tb_ready[b] = 0;
        tb_dir = 0; tb_act = 0; tb_pre = 0; tb_issue = 0;
        tb_act_bank = 0; tb_pre_bank = 0; tb_act_row = 0;
    endtask

    task automatic compute_exp();
        logic found;
        logic [TW-1:0] best;
        logic keep, conf;
        e_valid = 0; e_hit = 0; e_ap = 0; e_idx = 0;
        found = 0; best = 0;
        for (int i = 0; i < QD; i++)
            if (!e_hit && tb_valid[i] && tb_write[i] == tb_dir &&
                m_vld[tb_bank[i]] && m_row[tb_bank[i]] == tb_row[i]) begin
                e_valid = 1; e_hit = 1; e_idx = IW'(i);
            end
        if (!e_hit)
            for (int i = 0; i < QD; i++)
                if (tb_valid[i] && tb_write[i] == tb_dir &&
                    (!found || tb_ready[tb_bank[i]] < best)) begin
                    found = 1; best = tb_ready[tb_bank[i]];
                    e_valid = 1; e_idx = IW'(i);
                end
        e_bank = tb_bank[e_idx];
        keep = 0; conf = 0;
        for (int j = 0; j < QD; j++)
            if (tb_valid[j] && j != int'(e_idx) && tb_bank[j] == e_bank) begin
                if (tb_row[j] == tb_row[e_idx]) keep = 1;
                else conf = 1;
            end
        e_ap = e_valid && conf && !keep;
    endtask

    // inputs already driven; clock them in, update model, check after
    task automatic step(input string tag);
        @(posedge clk);
        #1;
        if (tb_pre) m_vld[tb_pre_bank] = 0;
        if (tb_issue && e_valid && e_ap) m_vld[e_bank] = 0;
        if (tb_act) begin m_vld[tb_act_bank] = 1; m_row[tb_act_bank] = tb_act_row; end
        compute_exp();
        @(negedge clk);
        check({tag, " R2 valid"}, g_valid, e_valid);
        if (e_valid) begin
            check({tag, e_hit ? " R3 R4 idx" : " R5 idx"}, g_idx, e_idx);
            check({tag, " R3 hit"}, g_hit, e_hit);
            check({tag, " R7 R8 autopre"}, g_ap, e_ap);
        end
        tb_act = 0; tb_pre = 0; tb_issue = 0;
    endtask

    task automatic put(input int i, input logic w, input int bank, input int row);
        tb_valid[i] = 1; tb_write[i] = w; tb_bank[i] = BW'(bank); tb_row[i] = RW'(row);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        clear_inputs();
        for (int b = 0; b < NB; b++) begin m_vld[b] = 0; m_row[b] = 0; end
        e_valid = 0; e_hit = 0; e_ap = 0; e_idx = 0; e_bank = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset grant", g_valid, 0);

        // R9: open bank 2 row 5; queue has two hits and a miss
        tb_act = 1; tb_act_bank = 2; tb_act_row = 5;
        put(0, 0, 1, 0); put(3, 0, 2, 5); put(5, 0, 2, 5);
        tb_ready[1] = 0; tb_ready[2] = 9;
        step("dir-hit");
        check("R4 lowest hit", g_idx, 3);
        check("R8 kept open", g_ap, 0);

        // R7: replace second hit with a conflicting row
        tb_valid[5] = 0; put(6, 1, 2, 7);
        step("dir-conflict");
        check("R7 autopre", g_ap, 1);

        // R12: inputs change between edges, outputs hold
        tb_valid[3] = 0;
        #1;
        check("R12 hold idx", g_idx, 3);
        // R11: issue the auto-precharged grant closes bank 2
        tb_valid[3] = 1; tb_issue = 1;
        step("dir-issue");
        check("R11 closed after issue", g_hit, 0);

        // R5: no hits, earliest bank wins, ties to lowest index
        clear_inputs();
        put(1, 0, 1, 3); put(2, 0, 3, 3); put(4, 0, 5, 3);
        tb_ready[1] = 9; tb_ready[3] = 4; tb_ready[5] = 4;
        step("dir-miss");
        check("R5 earliest", g_idx, 2);

        // R6: same pattern as writes
        for (int i = 0; i < QD; i++) tb_write[i] = 1;
        tb_dir = 1;
        step("dir-write");
        check("R6 write earliest", g_idx, 2);

        // R10: open then precharge
        tb_act = 1; tb_act_bank = 3; tb_act_row = 3;
        step("dir-act");
        check("R9 opened", g_hit, 1);
        tb_pre = 1; tb_pre_bank = 3;
        step("dir-pre");
        check("R10 closed", g_hit, 0);

        // R2: only the other direction present
        tb_dir = 0;
        step("dir-other-class");
        check("R2 none eligible", g_valid, 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < QD; i++) begin
                tb_valid[i] = ($urandom_range(0, 3) != 0);
                tb_write[i] = $urandom_range(0, 1);
                tb_bank[i]  = ($urandom_range(0, 4) == 0) ? BW'($urandom_range(0, 7))
                                                         : BW'($urandom_range(0, 3));
                tb_row[i]   = RW'($urandom_range(0, 3));
            end
            for (int b = 0; b < NB; b++) tb_ready[b] = TW'($urandom_range(0, 5));
            tb_dir      = $urandom_range(0, 1);
            tb_act      = ($urandom_range(0, 2) == 0);
            tb_act_bank = BW'($urandom_range(0, 7));
            tb_act_row  = RW'($urandom_range(0, 3));
            tb_pre      = ($urandom_range(0, 4) == 0);
            tb_pre_bank = BW'($urandom_range(0, 7));
            tb_issue    = $urandom_range(0, 1);
            step("random R6");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule